// File: doc/BRIEF.md
# Banked Instruction Queue with Decode Bypass

This block sits between an instruction fetch stage and an in-order decode stage that has several slots. Each cycle fetch offers a group of zero to `ENQ_W` instructions, packed from lane 0. Each instruction carries a 2-bit fetch fault code and a flag that marks an illegal compressed encoding. The queue stores a compact 3-bit exception code with each instruction and presents up to `DEQ_W` of the oldest entries to decode. Storage is split into `DEQ_W` banks, each with its own read row pointer, so that all output slots read in parallel.

Decode gives a global accept signal and a per-slot ready. Output valids depend only on queue state, the fetch inputs and accept; they never depend on ready. Decode takes slots strictly in order, so the number removed in a cycle is the length of the leading run of slots that are both valid and ready.

When the queue is empty, the incoming group goes straight to the output slots in the same cycle. Whatever decode does not take that cycle is written into storage. A redirect flush empties the block at once.

Top module: `ibuf_banked`

## Requirements
- R1: After reset no output slot is valid and `in_ready_o` is high.
- R2: Instructions leave the block in exactly the order they were accepted, with the instruction word unchanged, across pointer wraparound.
- R3: While the queue holds K entries and accept is high, output slots 0..min(K,DEQ_W)-1 are valid and no others. The number removed is the count of leading slots with valid and ready both high. A ready slot after a not-ready slot takes nothing.
- R4: While `dec_accept_i` is low no output slot is valid, whatever the ready inputs.
- R5: While the queue is empty, input lanes 0..in_num-1 appear on output slots 0..in_num-1 in the same cycle. Lanes that decode takes are never stored.
- R6: Bypassed lanes that decode does not take in that cycle are stored, and they come out later in order, ahead of later groups.
- R7: A cycle with `in_valid_i` low changes nothing, whatever `in_num_i` and the lane data hold.
- R8: `in_ready_o` is high exactly when no flush is present and DEPTH - (count - removed_this_cycle) >= in_num. Here count is the stored entries and removed_this_cycle is the stored entries taken this cycle (zero while bypassing).
- R9: With `flush_i` high, no output is valid and `in_ready_o` is low in that cycle. In the next cycle the queue is empty.
- R10: The output exception code is 0 none, 1 page fault, 2 guest page fault, 3 access fault, 4 illegal instruction. A nonzero fault code (1, 2, 3 on the 2-bit input) is passed through and wins over the illegal flag. The illegal flag alone gives 4.
- R11: The queue never holds more than DEPTH entries. A full queue with decode stalled hands out exactly DEPTH instructions once drained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Redirect: drop all contents this cycle |
| in_valid_i | input | 1 | Fetch group valid |
| in_num_i | input | clog2(ENQ_W+1) | Number of instructions in the group, lanes from 0 |
| in_instr_i | input | ENQ_W*INSTR_W | Instruction words, lane j at bits j*INSTR_W |
| in_fault_i | input | ENQ_W*2 | Fetch fault per lane: 0 none, 1 page, 2 guest page, 3 access |
| in_ill_i | input | ENQ_W | Illegal compressed instruction flag per lane |
| in_ready_o | output | 1 | Whole group can be taken this cycle |
| dec_accept_i | input | 1 | Decode able to take instructions this cycle |
| dec_ready_i | input | DEQ_W | Per-slot ready from decode |
| out_valid_o | output | DEQ_W | Per-slot valid |
| out_instr_o | output | DEQ_W*INSTR_W | Instruction word per slot |
| out_exc_o | output | DEQ_W*3 | Merged exception code per slot |

## Verification
Wrong pointer or bank-row state shows up within one cycle as the wrong word or the wrong order on an output slot. A wrong occupancy count shows up at once in the number of valid slots and in `in_ready_o` against the free-space rule. A bypass that loses or duplicates a lane is caught when later pops reach the reference queue, because every word is unique. The scoreboard checks every valid slot, the ready decision and the exception code on every cycle, including flushes in the middle of random traffic.

// File: rtl/ibuf_pkg.sv
`timescale 1ns/1ps
package ibuf_pkg;
  typedef enum logic [2:0] {
    EXC_NONE = 3'd0,
    EXC_PF   = 3'd1,
    EXC_GPF  = 3'd2,
    EXC_AF   = 3'd3,
    EXC_ILL  = 3'd4
  } exc_e;

  // fetch faults win over the illegal-instruction flag
  function automatic logic [2:0] merge_exc(input logic [1:0] fault, input logic ill);
    if (fault != 2'd0) return {1'b0, fault};
    return ill ? EXC_ILL : EXC_NONE;
  endfunction
endpackage

// File: rtl/ibuf_bank.sv
`timescale 1ns/1ps
module ibuf_bank #(
  parameter int ROWS = 4,
  parameter int EW   = 35,
  localparam int AW  = $clog2(ROWS)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [EW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [EW-1:0] rdata_o
);
  logic [EW-1:0] mem_q [ROWS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/ibuf_lead_ones.sv
`timescale 1ns/1ps
module ibuf_lead_ones #(
  parameter int W  = 4,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  bits_i,
  output logic [CW-1:0] cnt_o
);
  always_comb begin
    logic run;
    run   = 1'b1;
    cnt_o = '0;
    for (int i = 0; i < W; i++) begin
      if (run && bits_i[i]) cnt_o = CW'(i + 1);
      else run = 1'b0;
    end
  end
endmodule

// File: rtl/ibuf_banked.sv
`timescale 1ns/1ps
module ibuf_banked
  import ibuf_pkg::*;
#(
  parameter int DEPTH   = 16,  // power of two, multiple of DEQ_W
  parameter int ENQ_W   = 4,   // must not exceed DEQ_W
  parameter int DEQ_W   = 4,   // power of two, also the bank count
  parameter int INSTR_W = 32
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           flush_i,
  input  logic                           in_valid_i,
  input  logic [$clog2(ENQ_W+1)-1:0]     in_num_i,
  input  logic [ENQ_W*INSTR_W-1:0]       in_instr_i,
  input  logic [ENQ_W*2-1:0]             in_fault_i,
  input  logic [ENQ_W-1:0]               in_ill_i,
  output logic                           in_ready_o,
  input  logic                           dec_accept_i,
  input  logic [DEQ_W-1:0]               dec_ready_i,
  output logic [DEQ_W-1:0]               out_valid_o,
  output logic [DEQ_W*INSTR_W-1:0]       out_instr_o,
  output logic [DEQ_W*3-1:0]             out_exc_o
);
  localparam int NB   = DEQ_W;
  localparam int ROWS = DEPTH / NB;
  localparam int PW   = $clog2(DEPTH);
  localparam int BW   = $clog2(NB);
  localparam int RW   = $clog2(ROWS);
  localparam int CW   = PW + 1;
  localparam int NW   = $clog2(ENQ_W + 1);
  localparam int DW   = $clog2(DEQ_W + 1);
  localparam int EW   = INSTR_W + 3;

  logic [CW-1:0] wr_ptr_q, rd_ptr_q, cnt_q;
  logic [CW-1:0] wr_ptr_n, rd_ptr_n, cnt_n;
  logic [RW-1:0] bank_row_q [NB];
  logic [RW-1:0] bank_row_n [NB];
  logic [EW-1:0] bank_rdata [NB];
  logic [EW-1:0] in_ent     [ENQ_W];

  logic          empty, in_fire;
  logic [DW-1:0] lead;
  logic [CW-1:0] lead_w, deq_cnt, byp_acc, enq_cnt, in_num_w;
  logic [CW:0]   free_w;

  assign empty    = (cnt_q == '0);
  assign in_num_w = CW'(in_num_i);

  // merge fault and illegal flag into the stored code
  for (genvar j = 0; j < ENQ_W; j++) begin : g_in
    assign in_ent[j] = {merge_exc(in_fault_i[2*j +: 2], in_ill_i[j]),
                        in_instr_i[INSTR_W*j +: INSTR_W]};
  end

  // output slots: bypass lanes while empty, else banked reads
  for (genvar i = 0; i < DEQ_W; i++) begin : g_slot
    logic          byp_v, q_v;
    logic [BW-1:0] slot_bank;
    logic [EW-1:0] sel;
    assign slot_bank = rd_ptr_q[BW-1:0] + BW'(i);
    assign q_v       = (CW'(i) < cnt_q);
    if (i < ENQ_W) begin : g_byp
      assign byp_v = in_valid_i && (NW'(i) < in_num_i);
      assign sel   = empty ? in_ent[i] : bank_rdata[slot_bank];
    end else begin : g_nobyp
      assign byp_v = 1'b0;
      assign sel   = bank_rdata[slot_bank];
    end
    assign out_valid_o[i] = !flush_i && dec_accept_i && (empty ? byp_v : q_v);
    assign out_instr_o[INSTR_W*i +: INSTR_W] = sel[INSTR_W-1:0];
    assign out_exc_o[3*i +: 3] = sel[EW-1:INSTR_W];
  end

  // in-order acceptance: leading run of taken slots
  ibuf_lead_ones #(.W(DEQ_W)) u_lead (
    .bits_i (out_valid_o & dec_ready_i),
    .cnt_o  (lead)
  );

  assign lead_w  = CW'(lead);
  assign deq_cnt = empty ? '0 : lead_w;
  assign byp_acc = empty ? lead_w : '0;

  // free space after this cycle's dequeue must hold the whole group
  assign free_w     = (CW+1)'(DEPTH) - {1'b0, cnt_q} + {1'b0, deq_cnt};
  assign in_ready_o = !flush_i && (free_w >= (CW+1)'(in_num_i));
  assign in_fire    = in_valid_i && in_ready_o;
  assign enq_cnt    = in_fire ? (in_num_w - byp_acc) : '0;

  assign wr_ptr_n = wr_ptr_q + enq_cnt;
  assign rd_ptr_n = rd_ptr_q + deq_cnt;
  assign cnt_n    = cnt_q - deq_cnt + enq_cnt;

  // per-bank write steering and next read row
  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [BW-1:0] wofs;
    logic [CW-1:0] lane;
    logic [RW-1:0] wrow;
    logic          we;
    logic [EW-1:0] wdata;

    assign wofs = BW'(b) - wr_ptr_q[BW-1:0];
    assign lane = byp_acc + CW'(wofs);
    assign wrow = wr_ptr_q[PW-1:BW] + RW'(BW'(b) < wr_ptr_q[BW-1:0]);
    assign we   = in_fire && (lane < in_num_w);

    always_comb begin
      wdata = '0;
      for (int j = 0; j < ENQ_W; j++) begin
        if (CW'(j) == lane) wdata = in_ent[j];
      end
    end

    assign bank_row_n[b] = rd_ptr_n[PW-1:BW] + RW'(BW'(b) < rd_ptr_n[BW-1:0]);

    ibuf_bank #(.ROWS(ROWS), .EW(EW)) u_bank (
      .clk_i   (clk_i),
      .we_i    (we),
      .waddr_i (wrow),
      .wdata_i (wdata),
      .raddr_i (bank_row_q[b]),
      .rdata_o (bank_rdata[b])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      for (int b = 0; b < NB; b++) bank_row_q[b] <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      for (int b = 0; b < NB; b++) bank_row_q[b] <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_n;
      rd_ptr_q <= rd_ptr_n;
      cnt_q    <= cnt_n;
      for (int b = 0; b < NB; b++) bank_row_q[b] <= bank_row_n[b];
    end
  end
endmodule

// File: rtl/ibuf_banked_chk.sv
`timescale 1ns/1ps
module ibuf_banked_chk #(
  parameter int DEPTH = 16,
  parameter int DEQ_W = 4,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             flush_i,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic             dec_accept_i,
  input logic [DEQ_W-1:0] dec_ready_i,
  input logic [DEQ_W-1:0] out_valid_o,
  input logic [DEQ_W*3-1:0] out_exc_o,
  input logic [CW-1:0]    cnt_i,
  input logic [CW-1:0]    wr_ptr_i,
  input logic [CW-1:0]    rd_ptr_i
);
  assert_no_overflow_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= CW'(DEPTH));

  assert_ptr_gap_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i == (wr_ptr_i - rd_ptr_i));

  assert_flush_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> (out_valid_o == '0) && !in_ready_o);

  assert_flush_empties_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (cnt_i == '0));

  assert_accept_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_accept_i |-> (out_valid_o == '0));

  assert_valid_prefix_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o & (out_valid_o + DEQ_W'(1))) == '0);

  assert_idle_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush_i && !in_valid_i && ((out_valid_o & dec_ready_i) == '0)) |=> $stable(cnt_i));

  for (genvar i = 0; i < DEQ_W; i++) begin : g_exc
    assert_exc_legal_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o[i] |-> (out_exc_o[3*i +: 3] <= 3'd4));
  end
endmodule

bind ibuf_banked ibuf_banked_chk #(.DEPTH(DEPTH), .DEQ_W(DEQ_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .flush_i      (flush_i),
  .in_valid_i   (in_valid_i),
  .in_ready_o   (in_ready_o),
  .dec_accept_i (dec_accept_i),
  .dec_ready_i  (dec_ready_i),
  .out_valid_o  (out_valid_o),
  .out_exc_o    (out_exc_o),
  .cnt_i        (cnt_q),
  .wr_ptr_i     (wr_ptr_q),
  .rd_ptr_i     (rd_ptr_q)
);

// File: tb/tb_ibuf_banked.sv
`timescale 1ns/1ps
module tb_ibuf_banked;
  localparam int DEPTH = 16;
  localparam int ENQ_W = 4;
  localparam int DEQ_W = 4;
  localparam int IW    = 32;
  localparam int NW    = $clog2(ENQ_W + 1);

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                   rst_n;
  logic                   flush;
  logic                   in_valid;
  logic [NW-1:0]          in_num;
  logic [ENQ_W*IW-1:0]    in_instr;
  logic [ENQ_W*2-1:0]     in_fault;
  logic [ENQ_W-1:0]       in_ill;
  logic                   in_ready;
  logic                   dec_accept;
  logic [DEQ_W-1:0]       dec_ready;
  logic [DEQ_W-1:0]       out_valid;
  logic [DEQ_W*IW-1:0]    out_instr;
  logic [DEQ_W*3-1:0]     out_exc;

  ibuf_banked #(.DEPTH(DEPTH), .ENQ_W(ENQ_W), .DEQ_W(DEQ_W), .INSTR_W(IW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
    .in_valid_i(in_valid), .in_num_i(in_num), .in_instr_i(in_instr),
    .in_fault_i(in_fault), .in_ill_i(in_ill), .in_ready_o(in_ready),
    .dec_accept_i(dec_accept), .dec_ready_i(dec_ready),
    .out_valid_o(out_valid), .out_instr_o(out_instr), .out_exc_o(out_exc)
  );

  typedef struct packed {
    logic [IW-1:0] instr;
    logic [2:0]    exc;
    logic          spill;
  } item_t;

  item_t exp_q[$];
  int    n_cmp = 0, n_bad = 0, n_pop = 0, seq = 0;
  logic  mon_en = 1'b0;
  logic  fix_en = 1'b0;
  logic [ENQ_W*2-1:0] fix_fault;
  logic [ENQ_W-1:0]   fix_ill;

  // R10 encoding, written from the requirement
  function automatic logic [2:0] ref_code(input logic [1:0] f, input logic ill);
    case (f)
      2'd1: return 3'd1;
      2'd2: return 3'd2;
      2'd3: return 3'd3;
      default: return ill ? 3'd4 : 3'd0;
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic v, input int num, input logic [DEQ_W-1:0] rdy,
                     input logic acc, input logic fl);
    @(posedge clk); #1;
    in_valid = v; in_num = NW'(num); dec_ready = rdy; dec_accept = acc; flush = fl;
    for (int j = 0; j < ENQ_W; j++) begin
      in_instr[j*IW +: IW] = {8'hA5, 24'(seq)};
      seq++;
      if (fix_en) begin
        in_fault[j*2 +: 2] = fix_fault[j*2 +: 2];
        in_ill[j] = fix_ill[j];
      end else begin
        in_fault[j*2 +: 2] = ($urandom_range(0, 7) < 2) ? 2'($urandom_range(1, 3)) : 2'd0;
        in_ill[j] = ($urandom_range(0, 3) == 0);
      end
    end
  endtask

  task automatic drain();
    for (int k = 0; k < 20 && exp_q.size() != 0; k++) cyc(1'b0, 0, '1, 1'b1, 1'b0);
    cyc(1'b0, 0, '1, 1'b1, 1'b0);
  endtask

  // scoreboard monitor: push fetched items, pop and compare taken slots
  always @(negedge clk) begin
    if (mon_en) begin
      int qs, lead, deq_q;
      logic run, er;
      logic [DEQ_W-1:0] ev;
      string vt, pt;
      item_t it;
      qs = exp_q.size();
      for (int i = 0; i < DEQ_W; i++)
        ev[i] = dec_accept && !flush &&
                ((qs == 0) ? (in_valid && i < ENQ_W && i < int'(in_num)) : (i < qs));
      vt = !dec_accept ? "R4" : (flush ? "R9" : ((qs == 0) ? "R5" : "R3"));
      check(vt, 64'(out_valid), 64'(ev));
      lead = 0; run = 1'b1;
      for (int i = 0; i < DEQ_W; i++) begin
        if (run && ev[i] && dec_ready[i]) lead++;
        else run = 1'b0;
      end
      deq_q = (qs == 0) ? 0 : lead;
      er = !flush && ((DEPTH - qs + deq_q) >= int'(in_num));
      check(flush ? "R9" : "R8", 64'(in_ready), 64'(er));
      if (flush) begin
        exp_q.delete();
      end else begin
        if (in_valid && er) begin
          for (int j = 0; j < int'(in_num); j++) begin
            it.instr = in_instr[j*IW +: IW];
            it.exc   = ref_code(in_fault[j*2 +: 2], in_ill[j]);
            it.spill = (qs == 0);
            exp_q.push_back(it);
          end
        end
        for (int i = 0; i < lead; i++) begin
          it = exp_q.pop_front();
          n_pop++;
          pt = (qs == 0) ? "R5" : (it.spill ? "R6" : "R2");
          check(pt, 64'(out_instr[i*IW +: IW]), 64'(it.instr));
          check("R10", 64'(out_exc[i*3 +: 3]), 64'(it.exc));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int pop0;
    rst_n = 1'b0; flush = 1'b0; in_valid = 1'b0; in_num = '0; in_instr = '0;
    in_fault = '0; in_ill = '0; dec_accept = 1'b0; dec_ready = '0;
    fix_fault = '0; fix_ill = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1; dec_accept = 1'b1;
    @(negedge clk);
    check("R1", 64'(out_valid), 64'd0);
    check("R1", 64'(in_ready), 64'd1);
    mon_en = 1'b1;

    // R5: pure bypass
    repeat (5) cyc(1'b1, 4, '1, 1'b1, 1'b0);
    cyc(1'b1, 3, '1, 1'b1, 1'b0);
    // R6: partial bypass spills
    cyc(1'b1, 4, 4'b0011, 1'b1, 1'b0);
    cyc(1'b1, 2, 4'b0001, 1'b1, 1'b0);
    drain();
    // R3: holes in ready
    cyc(1'b1, 4, '0, 1'b1, 1'b0);
    cyc(1'b1, 4, '0, 1'b1, 1'b0);
    cyc(1'b0, 0, 4'b1101, 1'b1, 1'b0);
    cyc(1'b0, 0, 4'b1101, 1'b1, 1'b0);
    cyc(1'b0, 0, 4'b0111, 1'b1, 1'b0);
    drain();
    // R4: accept low
    cyc(1'b1, 4, '0, 1'b1, 1'b0);
    cyc(1'b0, 0, '1, 1'b0, 1'b0);
    cyc(1'b0, 0, '1, 1'b0, 1'b0);
    drain();
    // R8 / R11: fill, reject, then full queue with drain in same cycle
    pop0 = n_pop;
    repeat (6) cyc(1'b1, 4, '0, 1'b1, 1'b0);
    cyc(1'b1, 1, '0, 1'b1, 1'b0);
    cyc(1'b1, 4, '1, 1'b1, 1'b0);
    drain();
    check("R11", 64'(n_pop - pop0), 64'(DEPTH + 4));
    // R7: invalid cycles with garbage
    cyc(1'b1, 3, '0, 1'b1, 1'b0);
    repeat (3) cyc(1'b0, 4, '0, 1'b1, 1'b0);
    @(negedge clk);
    check("R7", 64'($countones(out_valid)), 64'd3);
    drain();
    // R10: directed fault / illegal mixes
    fix_en = 1'b1;
    fix_fault = {2'd0, 2'd1, 2'd2, 2'd3};
    fix_ill   = 4'b1111;
    cyc(1'b1, 4, '0, 1'b1, 1'b0);
    fix_fault = {2'd0, 2'd0, 2'd3, 2'd0};
    fix_ill   = 4'b0101;
    cyc(1'b1, 4, 4'b0011, 1'b1, 1'b0);
    fix_en = 1'b0;
    drain();
    // R9: flush with contents and input present
    cyc(1'b1, 4, '0, 1'b1, 1'b0);
    cyc(1'b1, 4, '0, 1'b1, 1'b0);
    cyc(1'b1, 4, '1, 1'b1, 1'b1);
    cyc(1'b0, 0, '1, 1'b1, 1'b0);
    @(negedge clk);
    check("R9", 64'(out_valid), 64'd0);
    // random traffic
    for (int k = 0; k < 3000; k++) begin
      cyc(($urandom_range(0, 9) < 7), int'($urandom_range(0, ENQ_W)),
          DEQ_W'($urandom), ($urandom_range(0, 9) != 0), ($urandom_range(0, 49) == 0));
    end
    drain();
    mon_en = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule